// File: doc/BRIEF.md
# Interrupt Request Qualifier and Acknowledge Starter

This block sits between the interrupt request lines of a chip and its processor core. Each of several sources presents a 3-bit encoded priority level, where 0 means "no request". The block combines the sources into the highest level currently requested. It samples that level on falling clock edges and accepts it only when two consecutive samples agree. It then compares the qualified level against the 3-bit priority mask, which software can write. The result is a pending level. This level is recomputed every cycle and is never held, so a stronger request replaces a weaker one, and a request that disappears stops being pending.

A pending level is taken only on a rising edge where the core reports an instruction boundary and no exception processing is running. When it takes the level, the block enters its acknowledge state. It drives the level onto the acknowledge address output and copies it into the mask, so that equal or lower requests stay blocked while the interrupt is serviced. The acknowledge stays active until the rest of the exception sequence returns a done strobe.

The controller has two states. `ST_IDLE` moves to `ST_ACK` through the transition *take*, which needs a pending level, a boundary and no busy. `ST_ACK` moves back to `ST_IDLE` through the transition *release*, which is an edge where the done strobe is high.

Top module: `irq_recognizer`

## Requirements
- R1: While reset is low, and after it is released, the mask reads 7, `iack` is 0, `iack_addr` is 0 and `pend_lvl` is 0.
- R2: The candidate level is the largest of the `N_SRC` source levels, where source k occupies bits [3k+2:3k] of `irq_req`.
- R3: A level becomes qualified only once the same nonzero value has been captured on two consecutive falling edges. A level present for a single falling edge never becomes pending and never starts an acknowledge.
- R4: `pend_lvl` equals the qualified level when that level is strictly greater than the mask. Otherwise it is 0, so a level equal to or below the mask is ignored.
- R5: The pending level is not stored. When a higher request is qualified it replaces a lower pending one, and when the request is withdrawn the pending level returns to 0.
- R6: The *take* transition happens only on a rising edge where the state is `ST_IDLE`, `pend_lvl` is nonzero, `insn_boundary` is 1 and `exc_busy` is 0.
- R7: On the edge that takes a level, `iack` becomes 1, `iack_addr` becomes that level and the mask is loaded with that level.
- R8: `iack` and `iack_addr` hold their values until an edge with `ack_done` high. On that edge the *release* transition returns `iack` to 0 and `iack_addr` to 0.
- R9: An edge with `mask_wr` high loads `mask_wdata` into the mask. On an edge that takes a level, the taken level wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; requests are sampled on its falling edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC*3 | Encoded request level of each source, 0 = none |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| exc_busy | input | 1 | Exception processing in progress, blocks acceptance |
| ack_done | input | 1 | Acknowledge cycle finished |
| mask_wr | input | 1 | Software mask write strobe |
| mask_wdata | input | 3 | New mask value |
| mask | output | 3 | Current priority mask |
| pend_lvl | output | 3 | Level that would be taken now, 0 = none |
| iack | output | 1 | Acknowledge cycle active |
| iack_addr | output | 3 | Level driven on the address bus during acknowledge, 0 otherwise |

## Verification
The hardest situation to reach from the ports is a pending level that changes before anything takes it. The bench holds `insn_boundary` low so nothing is accepted, qualifies a low level, and then raises a source to a higher level. It checks that the pending output first goes empty for the one falling edge on which the two samples disagree, and then reports the new level. It also withdraws the request and checks that the pending output empties. A near-exhaustive sweep over every mask value and every level of one source covers the strict comparison, the arbitration between sources and acceptance. In that sweep the second source's level is derived arithmetically from the first.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ack_state_e;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
    parameter int N_SRC = 2,
    parameter int LVL_W = 3
) (
    input  logic [N_SRC*LVL_W-1:0] req,
    output logic [LVL_W-1:0]       top_lvl
);
    logic [LVL_W-1:0] run [N_SRC+1];

    assign run[0] = '0;

    for (genvar g = 0; g < N_SRC; g++) begin : g_max
        logic [LVL_W-1:0] lvl_g;
        assign lvl_g      = req[g*LVL_W +: LVL_W];
        assign run[g + 1] = (lvl_g > run[g]) ? lvl_g : run[g];
    end

    assign top_lvl = run[N_SRC];
endmodule

// File: rtl/irq_edge_filter.sv
module irq_edge_filter #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_in,
    output logic [LVL_W-1:0] lvl_valid
);
    logic [LVL_W-1:0] smp_new;
    logic [LVL_W-1:0] smp_old;

    // capture on the falling edge of the system clock
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_new <= '0;
            smp_old <= '0;
        end else begin
            smp_new <= lvl_in;
            smp_old <= smp_new;
        end
    end

    // two matching samples qualify the level; a zero level stays zero
    assign lvl_valid = (smp_new == smp_old) ? smp_new : '0;
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int             LVL_W    = 3,
    parameter logic [LVL_W-1:0] MASK_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_valid,
    input  logic             insn_boundary,
    input  logic             exc_busy,
    input  logic             ack_done,
    input  logic             mask_wr,
    input  logic [LVL_W-1:0] mask_wdata,
    output logic [LVL_W-1:0] mask,
    output logic [LVL_W-1:0] pend_lvl,
    output logic             iack,
    output logic [LVL_W-1:0] iack_addr
);
    ack_state_e       state_q;
    ack_state_e       state_d;
    logic [LVL_W-1:0] mask_q;
    logic [LVL_W-1:0] addr_q;
    logic             take;
    logic             release_ack;

    assign pend_lvl    = (lvl_valid > mask_q) ? lvl_valid : '0;
    assign take        = (state_q == ST_IDLE) && (pend_lvl != '0)
                         && insn_boundary && !exc_busy;
    assign release_ack = (state_q == ST_ACK) && ack_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take)        state_d = ST_ACK;
            ST_ACK:  if (release_ack) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            addr_q <= '0;
        end else if (take) begin
            mask_q <= pend_lvl;
            addr_q <= pend_lvl;
        end else begin
            if (mask_wr)     mask_q <= mask_wdata;
            if (release_ack) addr_q <= '0;
        end
    end

    assign mask      = mask_q;
    assign iack      = (state_q == ST_ACK);
    assign iack_addr = addr_q;
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer #(
    parameter int N_SRC = 2,
    parameter int LVL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC*LVL_W-1:0] irq_req,
    input  logic                   insn_boundary,
    input  logic                   exc_busy,
    input  logic                   ack_done,
    input  logic                   mask_wr,
    input  logic [LVL_W-1:0]       mask_wdata,
    output logic [LVL_W-1:0]       mask,
    output logic [LVL_W-1:0]       pend_lvl,
    output logic                   iack,
    output logic [LVL_W-1:0]       iack_addr
);
    logic [LVL_W-1:0] cand_lvl;
    logic [LVL_W-1:0] qual_lvl;

    irq_src_merge #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_merge (
        .req     (irq_req),
        .top_lvl (cand_lvl)
    );

    irq_edge_filter #(.LVL_W(LVL_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (cand_lvl),
        .lvl_valid (qual_lvl)
    );

    irq_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .lvl_valid     (qual_lvl),
        .insn_boundary (insn_boundary),
        .exc_busy      (exc_busy),
        .ack_done      (ack_done),
        .mask_wr       (mask_wr),
        .mask_wdata    (mask_wdata),
        .mask          (mask),
        .pend_lvl      (pend_lvl),
        .iack          (iack),
        .iack_addr     (iack_addr)
    );
endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_boundary,
    input logic             exc_busy,
    input logic             ack_done,
    input logic [LVL_W-1:0] mask,
    input logic [LVL_W-1:0] pend_lvl,
    input logic             iack,
    input logic [LVL_W-1:0] iack_addr
);
    AST_PEND_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_lvl != '0) |-> (pend_lvl > mask)); // R4

    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> ($past(insn_boundary) && !$past(exc_busy))); // R6

    AST_TAKE_ABOVE_OLD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> (iack_addr > $past(mask))); // R6

    AST_TAKE_LOADS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack) |-> (mask == iack_addr)); // R7

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !ack_done) |=> (iack && $stable(iack_addr))); // R8

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && ack_done) |=> (!iack && iack_addr == '0)); // R8

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |-> (iack_addr == '0)); // R8
endmodule

bind irq_recognizer irq_recognizer_chk #(.LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .exc_busy      (exc_busy),
    .ack_done      (ack_done),
    .mask          (mask),
    .pend_lvl      (pend_lvl),
    .iack          (iack),
    .iack_addr     (iack_addr)
);

// File: tb/irq_recognizer_bench.sv
`timescale 1ns/1ps
module irq_recognizer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_a = '0;
    logic [2:0] src_b = '0;
    logic       insn_boundary = 1'b0;
    logic       exc_busy = 1'b0;
    logic       ack_done = 1'b0;
    logic       mask_wr = 1'b0;
    logic [2:0] mask_wdata = '0;
    logic [2:0] mask;
    logic [2:0] pend_lvl;
    logic       iack;
    logic [2:0] iack_addr;
    logic [5:0] irq_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign irq_req = {src_b, src_a};

    always #2.5 clk = ~clk;

    irq_recognizer u_irq_recognizer (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .insn_boundary(insn_boundary), .exc_busy(exc_busy), .ack_done(ack_done),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask(mask),
        .pend_lvl(pend_lvl), .iack(iack), .iack_addr(iack_addr)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_mask(input int m);
        mask_wr = 1'b1;
        mask_wdata = 3'(m);
        step();
        mask_wr = 1'b0;
    endtask

    task automatic finish_ack();
        ack_done = 1'b1;
        step();
        ack_done = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(); step();
        chk("R1 mask in reset", mask, 7);
        chk("R1 iack in reset", iack, 0);
        chk("R1 addr in reset", iack_addr, 0);
        rst_n = 1'b1;
        step();
        chk("R1 mask after reset", mask, 7);
        chk("R1 pend after reset", pend_lvl, 0);

        // sweep: every mask, every level of source a, derived level of source b
        for (int m = 0; m < 8; m++) begin
            for (int la = 0; la < 8; la++) begin
                int lb;
                int top;
                int expp;
                lb = (la * 5 + m * 3) % 8;
                top = (la > lb) ? la : lb;
                expp = (top > m) ? top : 0;
                write_mask(m);
                chk("R9 mask write", mask, m);
                src_a = 3'(la);
                src_b = 3'(lb);
                step(); step();
                chk("R2/R4 pending level", pend_lvl, expp);
                chk("R6 no take without boundary", iack, 0);
                insn_boundary = 1'b1;
                step();
                insn_boundary = 1'b0;
                chk("R6/R7 take", iack, (expp != 0) ? 1 : 0);
                chk("R7 mask after take", mask, (expp != 0) ? top : m);
                if (expp != 0) begin
                    chk("R7 ack address", iack_addr, top);
                    step();
                    chk("R8 ack held", iack, 1);
                    chk("R8 addr held", iack_addr, top);
                    finish_ack();
                    chk("R8 release", iack, 0);
                    chk("R8 addr cleared", iack_addr, 0);
                end
                src_a = '0;
                src_b = '0;
                step(); step();
                chk("R5 pending cleared", pend_lvl, 0);
            end
        end

        // R3 single-falling-edge pulse never qualifies
        write_mask(0);
        insn_boundary = 1'b1;
        src_a = 3'd4;
        step();
        chk("R3 pulse not pending", pend_lvl, 0);
        src_a = 3'd0;
        step();
        chk("R3 pulse not pending later", pend_lvl, 0);
        step();
        chk("R3 pulse never taken", iack, 0);
        insn_boundary = 1'b0;

        // R5 higher request replaces lower pending one, withdrawal clears it
        write_mask(1);
        src_a = 3'd2;
        step(); step();
        chk("R5 low pending", pend_lvl, 2);
        src_a = 3'd6;
        step();
        chk("R3 mismatch gap", pend_lvl, 0);
        step();
        chk("R5 replaced by higher", pend_lvl, 6);
        src_a = 3'd0;
        step();
        chk("R5 withdrawn", pend_lvl, 0);
        src_a = 3'd6;
        step(); step();
        insn_boundary = 1'b1;
        step();
        insn_boundary = 1'b0;
        chk("R7 replaced level taken", iack_addr, 6);
        finish_ack();
        src_a = 3'd0;
        step(); step();

        // R6 busy blocks acceptance until it drops
        write_mask(0);
        exc_busy = 1'b1;
        insn_boundary = 1'b1;
        src_a = 3'd3;
        step(); step(); step();
        chk("R6 busy blocks", iack, 0);
        exc_busy = 1'b0;
        step();
        insn_boundary = 1'b0;
        chk("R6 take after busy", iack, 1);
        chk("R7 addr after busy", iack_addr, 3);
        finish_ack();
        src_a = 3'd0;
        step(); step();

        // R9 take wins over a simultaneous mask write
        write_mask(2);
        src_b = 3'd5;
        step(); step();
        insn_boundary = 1'b1;
        mask_wr = 1'b1;
        mask_wdata = 3'd1;
        step();
        mask_wr = 1'b0;
        insn_boundary = 1'b0;
        chk("R9 take beats write", mask, 5);
        chk("R7 addr with write", iack_addr, 5);
        finish_ack();
        src_b = 3'd0;
        step(); step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule